// File: doc/BRIEF.md
# Serial Stereo Pixel Packet Deframer

This block takes a one-bit serial stream, sampled once per bit on an already recovered bit clock, and splits it into fixed 18-bit packets. Each packet holds the upper eight bits of one pixel from each of two image sensors, called the master and the slave. A high start bit opens the packet and a low stop bit closes it.

While idle, the receiver waits for a 1 and treats it as a start bit. It then takes the next seventeen samples. A low final sample gives a good packet: both pixel bytes are registered and shown with a one-cycle valid strobe. A high final sample is a framing fault: the packet is dropped, a one-cycle error pulse is raised, and the receiver goes back to waiting. Packets may follow one another with no gap between them.

Top module: `stereo_deframer`

## Requirements
- R1: While the synchronous active-high reset is asserted, and in the cycle after it, pix_valid and frame_err are 0 and pix_master and pix_slave are 0. The receiver then waits for a start bit.
- R2: While the receiver is waiting, a 0 sample is ignored: it produces no pix_valid and no frame_err pulse.
- R3: A 1 sample taken while waiting is packet bit 0. The next 17 samples are bits 1 to 17, in that order, with bit 17 the stop bit.
- R4: Packet bits 1 to 8 land in pix_master[0] to pix_master[7], which hold master pixel bits 2 to 9.
- R5: Packet bits 9 to 16 land in pix_slave[0] to pix_slave[7], which hold slave pixel bits 2 to 9.
- R6: When bit 17 samples as 0, pix_valid is 1 for exactly one cycle, the cycle after the stop sample. The new pixel bytes appear in that same cycle and hold until the next good packet.
- R7: When bit 17 samples as 1, frame_err is 1 for exactly one cycle, the cycle after the stop sample. pix_valid stays 0, and pix_master and pix_slave keep their previous values.
- R8: A start bit sampled in the cycle right after a stop bit begins a new packet, whether the stop bit was good or bad.
- R9: pix_valid and frame_err are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered bit clock; one sample per cycle |
| rst | input | 1 | Synchronous active-high reset |
| ser_in | input | 1 | Serial data sample |
| pix_master | output | 8 | Master pixel bits 9:2 of the last good packet |
| pix_slave | output | 8 | Slave pixel bits 9:2 of the last good packet |
| pix_valid | output | 1 | One-cycle strobe marking a new good packet |
| frame_err | output | 1 | One-cycle pulse marking a bad stop bit |

## Verification
The assertions assume that ser_in is a clean sample of each bit and that it changes only between rising edges. They do not assume any particular gap between packets. The stimulus drives every bit on the falling edge and sends well-formed packets. It adds runs of idle zeros, back-to-back packets, and packets whose stop bit is deliberately set high. It also puts a good packet straight after a bad one, so recovery from a framing fault is tested under the same zero-gap condition.

// File: rtl/deframer_pkg.sv
package deframer_pkg;
  typedef enum logic {
    ST_HUNT    = 1'b0,
    ST_COLLECT = 1'b1
  } hunt_state_e;
endpackage

// File: rtl/deframer_ctrl.sv
module deframer_ctrl
  import deframer_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic ser_in,
  output logic shift_en,
  output logic done_good,
  output logic done_bad
);
  localparam int PKT_LEN = 2 * PIX_W + 2;
  localparam int CW = $clog2(PKT_LEN);
  localparam logic [CW-1:0] LAST = CW'(PKT_LEN - 1);

  hunt_state_e state;
  logic [CW-1:0] cnt;
  logic at_stop;

  assign at_stop   = (state == ST_COLLECT) && (cnt == LAST);
  assign shift_en  = (state == ST_COLLECT) && (cnt != LAST);
  assign done_good = at_stop && !ser_in;
  assign done_bad  = at_stop && ser_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_HUNT;
      cnt   <= '0;
    end else begin
      unique case (state)
        ST_HUNT: begin
          if (ser_in) begin
            state <= ST_COLLECT;
            cnt   <= CW'(1);
          end
        end
        ST_COLLECT: begin
          if (cnt == LAST) begin
            state <= ST_HUNT;
            cnt   <= '0;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        default: state <= ST_HUNT;
      endcase
    end
  end

  // R3: the bit index never goes past the stop position
  a_r3_cnt_range: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
  // R8: after a stop sample the receiver is back to hunting
  a_r8_rehunt: assert property (@(posedge clk) disable iff (rst)
    at_stop |=> (state == ST_HUNT));
  // R2: a zero seen while hunting keeps the receiver hunting
  a_r2_idle_stays: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HUNT && !ser_in) |=> (state == ST_HUNT));
endmodule

// File: rtl/deframer_shift.sv
module deframer_shift #(
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             ser_in,
  output logic [PIX_W-1:0] lo_byte,
  output logic [PIX_W-1:0] hi_byte
);
  localparam int W = 2 * PIX_W;

  logic [W-1:0] sr;

  // new bits enter at the top, so the first payload bit ends at index 0
  always_ff @(posedge clk) begin
    if (rst) sr <= '0;
    else if (en) sr <= {ser_in, sr[W-1:1]};
  end

  assign lo_byte = sr[PIX_W-1:0];
  assign hi_byte = sr[W-1:PIX_W];

  // R4: the register moves only while payload bits are arriving
  a_r4_shift_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(en) |-> $stable(sr));
endmodule

// File: rtl/deframer_out.sv
module deframer_out #(
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             good,
  input  logic             bad,
  input  logic [PIX_W-1:0] lo_byte,
  input  logic [PIX_W-1:0] hi_byte,
  output logic [PIX_W-1:0] master,
  output logic [PIX_W-1:0] slave,
  output logic             valid,
  output logic             err
);
  always_ff @(posedge clk) begin
    if (rst) begin
      master <= '0;
      slave  <= '0;
      valid  <= 1'b0;
      err    <= 1'b0;
    end else begin
      valid <= good;
      err   <= bad;
      if (good) begin
        master <= lo_byte;
        slave  <= hi_byte;
      end
    end
  end

  // R7: a framing fault leaves the pixel bytes untouched
  a_r7_err_hold: assert property (@(posedge clk) disable iff (rst)
    err |-> ($stable(master) && $stable(slave)));
  // R6: the strobe lasts a single cycle
  a_r6_one_cycle: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);
  // R7: the error pulse lasts a single cycle
  a_r7_one_cycle: assert property (@(posedge clk) disable iff (rst)
    err |=> !err);
endmodule

// File: rtl/stereo_deframer.sv
module stereo_deframer #(
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ser_in,
  output logic [PIX_W-1:0] pix_master,
  output logic [PIX_W-1:0] pix_slave,
  output logic             pix_valid,
  output logic             frame_err
);
  logic shift_en, done_good, done_bad;
  logic [PIX_W-1:0] lo_byte, hi_byte;

  deframer_ctrl #(.PIX_W(PIX_W)) u_ctrl (
    .clk(clk), .rst(rst), .ser_in(ser_in),
    .shift_en(shift_en), .done_good(done_good), .done_bad(done_bad)
  );

  deframer_shift #(.PIX_W(PIX_W)) u_shift (
    .clk(clk), .rst(rst), .en(shift_en), .ser_in(ser_in),
    .lo_byte(lo_byte), .hi_byte(hi_byte)
  );

  deframer_out #(.PIX_W(PIX_W)) u_out (
    .clk(clk), .rst(rst), .good(done_good), .bad(done_bad),
    .lo_byte(lo_byte), .hi_byte(hi_byte),
    .master(pix_master), .slave(pix_slave),
    .valid(pix_valid), .err(frame_err)
  );

  // R9: strobe and error pulse never coincide
  a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(pix_valid && frame_err));
  // R1: reset clears both pulses
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!pix_valid && !frame_err));
endmodule

// File: tb/stereo_deframer_test.sv
module stereo_deframer_test;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 100000;

  typedef struct {
    logic       is_err;
    logic [7:0] m;
    logic [7:0] s;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_in = 1'b0;
  logic [7:0] pix_master, pix_slave;
  logic pix_valid, frame_err;

  int checks = 0;
  int fails  = 0;
  exp_t exp_q[$];
  logic [7:0] last_m = 8'h00;
  logic [7:0] last_s = 8'h00;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  stereo_deframer uut (
    .clk(clk), .rst(rst), .ser_in(ser_in),
    .pix_master(pix_master), .pix_slave(pix_slave),
    .pix_valid(pix_valid), .frame_err(frame_err)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ser_in = 1'b0;
    end
  endtask

  // R3: bit 0 first; start=1, bits 1..8 master (R4), 9..16 slave (R5), stop
  task automatic send_pkt(input logic [7:0] m, input logic [7:0] s, input logic stop);
    exp_t e;
    logic [17:0] pkt;
    pkt = {stop, s, m, 1'b1};
    e.is_err = stop;
    if (!stop) begin
      last_m = m;
      last_s = s;
    end
    e.m = last_m;
    e.s = last_s;
    exp_q.push_back(e);
    for (int i = 0; i < 18; i++) begin
      @(negedge clk);
      ser_in = pkt[i];
    end
  endtask

  // monitor: pops one expected item for every strobe or error pulse
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (!rst && (pix_valid || frame_err)) begin
        check("R9 valid and error together", int'(pix_valid && frame_err), 0);
        if (exp_q.size() == 0) begin
          check("R2 unexpected output", 1, 0);
        end else begin
          e = exp_q.pop_front();
          check("R6 valid strobe", int'(pix_valid), int'(!e.is_err));
          check("R7 framing error", int'(frame_err), int'(e.is_err));
          check("R4 master byte", int'(pix_master), int'(e.m));
          check("R5 slave byte", int'(pix_slave), int'(e.s));
        end
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    ser_in = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state while held in reset
    check("R1 valid in reset", int'(pix_valid), 0);
    check("R1 error in reset", int'(frame_err), 0);
    check("R1 master in reset", int'(pix_master), 0);
    check("R1 slave in reset", int'(pix_slave), 0);
    ser_in = 1'b0;
    rst = 1'b0;
    // R2: idle zeros produce nothing (monitor flags any pulse)
    idle(12);
    check("R2 idle no valid", int'(pix_valid), 0);
    send_pkt(8'hA5, 8'h3C, 1'b0);
    idle(3);
    // R8: back-to-back good packets
    send_pkt(8'h01, 8'h80, 1'b0);
    send_pkt(8'hFF, 8'h00, 1'b0);
    send_pkt(8'h00, 8'hFF, 1'b0);
    idle(2);
    // R7: bad stop bit keeps previous bytes
    send_pkt(8'h5A, 8'hC3, 1'b1);
    // R8: good packet right after a bad one
    send_pkt(8'h96, 8'h69, 1'b0);
    send_pkt(8'h12, 8'h34, 1'b1);
    send_pkt(8'h7E, 8'hE7, 1'b1);
    idle(5);
    // R6: data holds after strobe ends
    check("R6 valid low after strobe", int'(pix_valid), 0);
    check("R6 master holds", int'(pix_master), 8'h96);
    check("R6 slave holds", int'(pix_slave), 8'h69);
    send_pkt(8'h80, 8'h01, 1'b0);
    idle(4);
    check("R6 all expected outputs seen", exp_q.size(), 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule